// File: doc/BRIEF.md
# Accelerometer Sample Buffer with Byte-Count Status

This block sits inside a three-axis motion sensor. It holds acceleration samples until a host collects them over a byte-wide register port. Each time the sensor data path raises its sample strobe, one sample enters the buffer. A sample is three signed 16-bit axis values, six bytes in all. The host drains the buffer one byte per read, always from the same data register. The register address never advances, so a burst read from one address empties consecutive bytes.

The host can see how many bytes are waiting through an 8-bit status register. The full buffer holds more bytes than 8 bits can express, so the status saturates. The host also sets a watermark in whole samples. When enough samples are waiting, the block raises an interrupt pin. The host can switch the pin on or off, choose its active level, and pick level or single-pulse signalling. Reading the data out is the only acknowledge the interrupt needs.

Top module: `sensor_byte_fifo`

## Requirements
- R1: The buffer holds 43 samples. A sample offered while all 43 slots are occupied is dropped, and the stored bytes still come out unchanged and in order.
- R2: Reading address 1 returns the number of stored bytes. Any count from 255 up to the full 258 reads as 255 (0xFF); smaller counts read exactly.
- R3: Each read of address 0 returns the next stored byte. Samples leave oldest first. Within a sample the byte order is X low, X high, Y low, Y high, Z low, Z high, with X in bits 15:0 of the sample input, Y in bits 31:16 and Z in bits 47:32. Every read value appears on the read-data output in the cycle after the read strobe.
- R4: Any write to address 4 empties the buffer at once, and the byte count reads 0 afterwards. If a sample arrives in the same cycle, the clear wins and the sample is dropped.
- R5: Address 2 holds the watermark in samples. A written value above 43 is stored and read back as 43. A watermark of 0 never raises the interrupt.
- R6: The watermark condition is true while the number of occupied sample slots is at or above the watermark. A partly read sample still occupies its slot. The condition clears by itself once reads bring the count below the watermark.
- R7: Address 3 bit 0 enables storage. While it is 0, incoming samples are ignored.
- R8: The condition reaches the pin only when address 3 bit 1 (watermark routing) and bit 2 (pin enable) are both 1. Otherwise the pin rests at its inactive level.
- R9: Address 3 bit 3 set to 1 makes the pin active-low. The pin is registered and reflects a state change one cycle after it.
- R10: With address 3 bit 4 at 0 the pin holds its active level for as long as the condition lasts. With bit 4 at 1 the pin gives a one-cycle active pulse each time the condition becomes true.
- R11: A read of address 0 while the buffer is empty returns 0x00 and changes neither the count nor the read position.
- R12: A sample push and a data read in the same cycle both take effect: the count rises by 6 and falls by 1.
- R13: After reset the byte count, the control register and the watermark all read 0, and the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe, one sample per cycle |
| smp_data | input | 48 | Sample: X in [15:0], Y in [31:16], Z in [47:32] |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| irq_pin | output | 1 | Watermark interrupt pin |

## Verification
Corrupted slot or offset state shows up at the ports on the very next status read, because the byte count is computed from those two values. A wrong read pointer shows up as misordered bytes on the data register within one sample. A slot count that overruns the 43-slot capacity would hide a dropped overflow sample, so the bench fills the buffer past capacity and checks the last sample that comes out. An interrupt fault is visible on the pin one cycle after the slot count crosses the watermark.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

    // Register map of the byte port
    typedef enum logic [2:0] {
        RA_DATA  = 3'd0,
        RA_COUNT = 3'd1,
        RA_WMARK = 3'd2,
        RA_CTRL  = 3'd3,
        RA_CLEAR = 3'd4
    } reg_addr_e;

    // Control register fields, bit 0 is the LSB
    typedef struct packed {
        logic pulse;     // bit 4: single pulse instead of level
        logic act_low;   // bit 3: active-low pin
        logic pin_en;    // bit 2: pin enable
        logic wm_route;  // bit 1: watermark routed to the pin
        logic buf_en;    // bit 0: storage enable
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);
    localparam int unsigned STATUS_MAX = 255;

    // Saturating 8-bit view of a byte count
    function automatic logic [7:0] byte_status(input logic [15:0] bytes);
        return (bytes >= 16'(STATUS_MAX)) ? 8'hFF : bytes[7:0];
    endfunction

    // Limit a written watermark to the buffer depth
    function automatic logic [7:0] clamp_wm(input logic [7:0] v, input logic [7:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/sbf_store.sv
module sbf_store
    import sbf_pkg::*;
#(
    parameter int unsigned DEPTH  = 43,
    parameter int unsigned AXES   = 3,
    parameter int unsigned AXIS_W = 16,
    localparam int unsigned SW     = AXES * AXIS_W,
    localparam int unsigned SBYTES = SW / 8,
    localparam int unsigned PW     = $clog2(DEPTH),
    localparam int unsigned CW     = $clog2(DEPTH + 1),
    localparam int unsigned OFF_W  = $clog2(SBYTES),
    localparam int unsigned BCW    = $clog2(DEPTH * SBYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [SW-1:0]    push_word,
    input  logic             pop,
    input  logic             clear,
    output logic [7:0]       head_byte,
    output logic             empty,
    output logic [CW-1:0]    slots,
    output logic [OFF_W-1:0] head_off,
    output logic [BCW-1:0]   byte_cnt
);

    logic [SW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          full, do_push, do_pop, retire;
    logic [SW-1:0] head_word;
    logic [7:0]    lanes [SBYTES];

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (slots == '0);
    assign full    = (slots == CW'(DEPTH));
    assign do_push = push && !full && !clear;
    assign do_pop  = pop && !empty && !clear;
    assign retire  = do_pop && (head_off == OFF_W'(SBYTES - 1));

    // Sample storage, no reset needed
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            head_off <= '0;
            slots    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (do_pop) begin
                if (retire) begin
                    head_off <= '0;
                    rd_ptr   <= ptr_next(rd_ptr);
                end else begin
                    head_off <= head_off + 1'b1;
                end
            end
            slots <= slots + CW'(do_push) - CW'(retire);
        end
    end

    // Byte lanes of the head sample, little-endian per axis
    assign head_word = mem[rd_ptr];
    for (genvar g = 0; g < SBYTES; g++) begin : g_lane
        assign lanes[g] = head_word[8*g +: 8];
    end
    assign head_byte = lanes[head_off];

    assign byte_cnt = BCW'(slots) * BCW'(SBYTES) - BCW'(head_off);

endmodule

// File: rtl/sbf_regs.sv
module sbf_regs
    import sbf_pkg::*;
#(
    parameter int unsigned DEPTH = 43,
    parameter int unsigned BCW   = 9,
    parameter int unsigned CW    = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2:0]     bus_addr,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [7:0]     bus_wdata,
    input  logic [7:0]     head_byte,
    input  logic           empty,
    input  logic [BCW-1:0] byte_cnt,
    output logic [7:0]     bus_rdata,
    output ctrl_t          ctrl,
    output logic [CW-1:0]  wmark,
    output logic           pop,
    output logic           clear
);

    reg_addr_e ra;
    logic [7:0] rd_mux;

    assign ra    = reg_addr_e'(bus_addr);
    assign pop   = bus_rd && (ra == RA_DATA);
    assign clear = bus_wr && (ra == RA_CLEAR);

    always_comb begin
        case (ra)
            RA_DATA:  rd_mux = empty ? 8'h00 : head_byte;
            RA_COUNT: rd_mux = byte_status(16'(byte_cnt));
            RA_WMARK: rd_mux = 8'(wmark);
            RA_CTRL:  rd_mux = 8'(ctrl);
            default:  rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            wmark     <= '0;
            bus_rdata <= 8'h00;
        end else begin
            if (bus_wr && ra == RA_CTRL) begin
                ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            end
            if (bus_wr && ra == RA_WMARK) begin
                wmark <= CW'(clamp_wm(bus_wdata, 8'(DEPTH)));
            end
            if (bus_rd) begin
                bus_rdata <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/sbf_irq.sv
module sbf_irq
    import sbf_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] slots,
    input  logic [CW-1:0] wmark,
    input  ctrl_t         ctrl,
    output logic          irq_pin
);

    logic cond, active, active_q, drive;

    assign cond   = (wmark != '0) && (slots >= wmark);
    assign active = cond && ctrl.wm_route && ctrl.pin_en;
    assign drive  = ctrl.pulse ? (active && !active_q) : active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            irq_pin  <= 1'b0;
        end else begin
            active_q <= active;
            irq_pin  <= drive ^ ctrl.act_low;
        end
    end

endmodule

// File: rtl/sensor_byte_fifo.sv
module sensor_byte_fifo
    import sbf_pkg::*;
#(
    parameter int unsigned DEPTH  = 43,
    parameter int unsigned AXES   = 3,
    parameter int unsigned AXIS_W = 16,
    localparam int unsigned SW     = AXES * AXIS_W,
    localparam int unsigned SBYTES = SW / 8,
    localparam int unsigned CW     = $clog2(DEPTH + 1),
    localparam int unsigned OFF_W  = $clog2(SBYTES),
    localparam int unsigned BCW    = $clog2(DEPTH * SBYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic [SW-1:0] smp_data,
    input  logic [2:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    output logic          irq_pin
);

    ctrl_t             ctrl;
    logic [CW-1:0]     wmark;
    logic [CW-1:0]     slots;
    logic [OFF_W-1:0]  head_off;
    logic [BCW-1:0]    byte_cnt;
    logic [7:0]        head_byte;
    logic              empty, pop, clear;

    sbf_store #(.DEPTH(DEPTH), .AXES(AXES), .AXIS_W(AXIS_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (smp_valid && ctrl.buf_en),
        .push_word (smp_data),
        .pop       (pop),
        .clear     (clear),
        .head_byte (head_byte),
        .empty     (empty),
        .slots     (slots),
        .head_off  (head_off),
        .byte_cnt  (byte_cnt)
    );

    sbf_regs #(.DEPTH(DEPTH), .BCW(BCW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .head_byte (head_byte),
        .empty     (empty),
        .byte_cnt  (byte_cnt),
        .bus_rdata (bus_rdata),
        .ctrl      (ctrl),
        .wmark     (wmark),
        .pop       (pop),
        .clear     (clear)
    );

    sbf_irq #(.CW(CW)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .slots   (slots),
        .wmark   (wmark),
        .ctrl    (ctrl),
        .irq_pin (irq_pin)
    );

endmodule

// File: rtl/sbf_checker.sv
module sbf_checker
    import sbf_pkg::*;
#(
    parameter int unsigned DEPTH = 43,
    parameter int unsigned CW    = 6,
    parameter int unsigned OFF_W = 3,
    parameter int unsigned SBYTES = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_valid,
    input logic [2:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [7:0]       bus_rdata,
    input logic             irq_pin,
    input ctrl_t            ctrl,
    input logic [CW-1:0]    slots,
    input logic [OFF_W-1:0] head_off
);

    logic rd_data, wr_clr;
    assign rd_data = bus_rd && (bus_addr == 3'd0);
    assign wr_clr  = bus_wr && (bus_addr == 3'd4);

    // R1: never more occupied slots than capacity
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst)
        slots <= CW'(DEPTH));

    // R1: a full buffer stays full while nothing is read or cleared
    a_r1_full_hold: assert property (@(posedge clk) disable iff (rst)
        (slots == CW'(DEPTH) && !rd_data && !wr_clr) |=> (slots == CW'(DEPTH)));

    // R4: clear empties the buffer in the next cycle
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> (slots == '0 && head_off == '0));

    // R7: with storage disabled the occupancy cannot grow
    a_r7_no_store: assert property (@(posedge clk) disable iff (rst)
        !ctrl.buf_en |=> (slots <= $past(slots)));

    // R8: pin rests at its inactive level unless routed and enabled
    a_r8_pin_gated: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.pin_en && ctrl.wm_route) |=> (irq_pin == $past(ctrl.act_low)));

    // R11: empty read returns zero and leaves the buffer empty
    a_r11_empty_read: assert property (@(posedge clk) disable iff (rst)
        (rd_data && slots == '0 && !smp_valid) |=> (bus_rdata == 8'h00 && slots == '0));

    // R12: push with a mid-sample pop gains exactly one slot
    a_r12_push_pop: assert property (@(posedge clk) disable iff (rst)
        (rd_data && smp_valid && ctrl.buf_en && !wr_clr && slots != '0 &&
         slots != CW'(DEPTH) && head_off != OFF_W'(SBYTES - 1))
        |=> (slots == $past(slots) + 1'b1));

endmodule

bind sensor_byte_fifo sbf_checker #(
    .DEPTH(DEPTH), .CW(CW), .OFF_W(OFF_W), .SBYTES(SBYTES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_pin   (irq_pin),
    .ctrl      (ctrl),
    .slots     (slots),
    .head_off  (head_off)
);

// File: tb/sim_sensor_byte_fifo.sv
`timescale 1ns/1ps
module sim_sensor_byte_fifo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [47:0] smp_data = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_pin;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sensor_byte_fifo u0 (
        .clk, .rst, .smp_valid, .smp_data, .bus_addr, .bus_wr,
        .bus_rd, .bus_wdata, .bus_rdata, .irq_pin
    );

    // Vector: op[1:0] addr[2:0] data[15:0] expect[7:0] req[3:0]
    localparam int OP_WR = 0, OP_RD = 1, OP_PUSH = 2;
    localparam int NV = 26;
    localparam logic [32:0] VEC [NV] = '{
        {2'd0, 3'd3, 16'h0001, 8'h00, 4'd7},
        {2'd2, 3'd0, 16'h1234, 8'h00, 4'd3},
        {2'd1, 3'd1, 16'h0000, 8'h06, 4'd2},
        {2'd2, 3'd0, 16'hABCD, 8'h00, 4'd3},
        {2'd1, 3'd1, 16'h0000, 8'h0C, 4'd2},
        {2'd1, 3'd0, 16'h0000, 8'h34, 4'd3},
        {2'd1, 3'd0, 16'h0000, 8'h12, 4'd3},
        {2'd1, 3'd1, 16'h0000, 8'h0A, 4'd2},
        {2'd1, 3'd0, 16'h0000, 8'h35, 4'd3},
        {2'd1, 3'd0, 16'h0000, 8'h13, 4'd3},
        {2'd1, 3'd0, 16'h0000, 8'h36, 4'd3},
        {2'd1, 3'd0, 16'h0000, 8'h14, 4'd3},
        {2'd1, 3'd0, 16'h0000, 8'hCD, 4'd3},
        {2'd1, 3'd0, 16'h0000, 8'hAB, 4'd3},
        {2'd1, 3'd0, 16'h0000, 8'hCE, 4'd3},
        {2'd1, 3'd0, 16'h0000, 8'hAC, 4'd3},
        {2'd1, 3'd0, 16'h0000, 8'hCF, 4'd3},
        {2'd1, 3'd0, 16'h0000, 8'hAD, 4'd3},
        {2'd1, 3'd1, 16'h0000, 8'h00, 4'd2},
        {2'd1, 3'd0, 16'h0000, 8'h00, 4'd11},
        {2'd1, 3'd1, 16'h0000, 8'h00, 4'd11},
        {2'd0, 3'd2, 16'h0032, 8'h00, 4'd5},
        {2'd1, 3'd2, 16'h0000, 8'h2B, 4'd5},
        {2'd0, 3'd3, 16'h0000, 8'h00, 4'd7},
        {2'd2, 3'd0, 16'h1234, 8'h00, 4'd7},
        {2'd1, 3'd1, 16'h0000, 8'h00, 4'd7}
    };

    function automatic logic [47:0] samp(input logic [15:0] s);
        return {s + 16'h0202, s + 16'h0101, s};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic push(input logic [15:0] s);
        @(negedge clk);
        smp_data = samp(s); smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic push_pop(input logic [15:0] s, output logic [7:0] v);
        @(negedge clk);
        smp_data = samp(s); smp_valid = 1'b1;
        bus_addr = 3'd0; bus_rd = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0; bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R13: reset state
        check("R13 pin", 32'(irq_pin), 32'h0);
        rd(3'd1, v); check("R13 count", 32'(v), 32'h0);
        rd(3'd3, v); check("R13 ctrl", 32'(v), 32'h0);
        rd(3'd2, v); check("R13 wmark", 32'(v), 32'h0);

        // Vector table walk (R2 R3 R5 R7 R11)
        for (int i = 0; i < NV; i++) begin
            logic [32:0] e;
            e = VEC[i];
            case (int'(e[32:31]))
                OP_WR:   wr(e[30:28], e[19:12]);
                OP_PUSH: push(e[27:12]);
                default: begin
                    rd(e[30:28], v);
                    check($sformatf("R%0d vec%0d", e[3:0], i), 32'(v), 32'(e[11:4]));
                end
            endcase
        end

        // R1 R2: fill past capacity
        wr(3'd4, 8'h00);
        wr(3'd3, 8'h01);
        for (int i = 0; i < 43; i++) push(16'(i * 16));
        rd(3'd1, v); check("R2 full saturates", 32'(v), 32'hFF);
        push(16'hFFFF);
        rd(3'd1, v); check("R1 overflow count", 32'(v), 32'hFF);
        rd(3'd0, v); check("R1 first byte", 32'(v), 32'h00);
        rd(3'd1, v); check("R2 257 saturates", 32'(v), 32'hFF);
        for (int i = 0; i < 5; i++) rd(3'd0, v);
        rd(3'd1, v); check("R2 exact 252", 32'(v), 32'hFC);
        for (int i = 0; i < 41 * 6; i++) rd(3'd0, v);
        rd(3'd0, v); check("R1 last sample XL", 32'(v), 32'hA0);
        rd(3'd0, v); check("R1 last sample XH", 32'(v), 32'h02);
        for (int i = 0; i < 3; i++) rd(3'd0, v);
        rd(3'd0, v); check("R1 last sample ZH", 32'(v), 32'h04);
        rd(3'd1, v); check("R1 drained", 32'(v), 32'h00);

        // R4: clear
        push(16'h1111); push(16'h2222);
        wr(3'd4, 8'h5A);
        rd(3'd1, v); check("R4 count after clear", 32'(v), 32'h00);
        rd(3'd0, v); check("R4 data after clear", 32'(v), 32'h00);

        // R12: simultaneous push and pop
        push(16'h1234);
        push_pop(16'hABCD, v); check("R12 popped byte", 32'(v), 32'h34);
        rd(3'd1, v); check("R12 count", 32'(v), 32'h0B);

        // R6 R8 R9 R10: watermark interrupt
        wr(3'd4, 8'h00);
        wr(3'd2, 8'h02);
        wr(3'd3, 8'h07);
        push(16'h0001); idle();
        check("R6 below mark", 32'(irq_pin), 32'h0);
        push(16'h0002); idle();
        check("R6 at mark", 32'(irq_pin), 32'h1);
        rd(3'd0, v); idle();
        check("R6 partial sample holds", 32'(irq_pin), 32'h1);
        for (int i = 0; i < 5; i++) rd(3'd0, v);
        idle();
        check("R6 self clears", 32'(irq_pin), 32'h0);
        push(16'h0003); idle();
        wr(3'd3, 8'h05); idle();
        check("R8 not routed", 32'(irq_pin), 32'h0);
        wr(3'd3, 8'h03); idle();
        check("R8 pin disabled", 32'(irq_pin), 32'h0);
        wr(3'd3, 8'h0F); idle();
        check("R9 active low asserted", 32'(irq_pin), 32'h0);
        wr(3'd4, 8'h00); idle();
        check("R9 active low idle", 32'(irq_pin), 32'h1);
        wr(3'd3, 8'h17);
        push(16'h0004);
        push(16'h0005);
        idle();
        check("R10 pulse high", 32'(irq_pin), 32'h1);
        idle();
        check("R10 pulse ends", 32'(irq_pin), 32'h0);
        wr(3'd3, 8'h07); wr(3'd2, 8'h00); idle();
        check("R5 zero mark never fires", 32'(irq_pin), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule